// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver with Error Status

This block recovers bytes from an asynchronous, idle-high serial line. It runs on a clock at sixteen times the bit rate and detects the low start bit. It takes one sample near the middle of each following bit and assembles a frame. The frame holds eight data bits sent least significant bit first, then a parity bit, then a stop bit. Each completed byte is handed to a host through a simple parallel interface.

The host waits for `byte_ready`, then pulls the active-low `rd_n` strobe. While the strobe is low the byte appears on `rx_byte`, and the strobe clears `byte_ready`. Three status flags describe the byte that was delivered: a parity mismatch, a missing stop bit, and a byte that replaced an unread predecessor. The flags keep their values until the next frame completes. The parity sense, even or odd, is chosen by a mode input.

Top module: `rxu_receiver`

## Requirements
- R1: After reset, `byte_ready`, `err_parity`, `err_frame` and `err_overrun` are 0, and `rx_byte` is 0 while `rd_n` is high.
- R2: A high-to-low transition on the synchronised line starts a frame only if the line is still low 8 clocks later. A low pulse shorter than that produces no byte and leaves `byte_ready` at 0.
- R3: Data bits are sampled every 16 clocks after the start confirmation, least significant bit first. The frame then takes one parity sample and one stop sample. Completion of the frame sets `byte_ready` to 1 and stores the byte.
- R4: With `odd_parity`=0 the count of ones over the 8 data bits plus the parity bit must be even. With `odd_parity`=1 it must be odd. A mismatch sets `err_parity`=1 for that byte. `odd_parity` must stay stable during a frame.
- R5: A stop sample of 0 sets `err_frame`=1 for that byte, and the byte is still delivered with `byte_ready`=1.
- R6: A frame that completes while `byte_ready` is 1 and `rd_n` is high sets `err_overrun`=1. The new byte replaces the unread one. A frame that completes with `byte_ready` at 0 gives `err_overrun`=0.
- R7: While `rd_n` is 0, `rx_byte` shows the stored byte; otherwise it is 0. A clock edge with `rd_n`=0 clears `byte_ready`, unless a frame completes on that same edge.
- R8: The three error flags change only when a frame completes; reading the byte does not clear them.
- R9: Frames sent back to back, with the next start bit directly after a full stop bit, are all received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at 16 times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_serial | input | 1 | Serial input line, idle high |
| odd_parity | input | 1 | Parity sense: 1 odd, 0 even |
| rd_n | input | 1 | Active-low read strobe |
| rx_byte | output | DATA_W | Received byte while `rd_n` is low, else 0 |
| byte_ready | output | 1 | A received byte is waiting to be read |
| err_parity | output | 1 | Parity mismatch on the current byte |
| err_frame | output | 1 | Stop bit of the current byte was low |
| err_overrun | output | 1 | Current byte overwrote an unread byte |

## Verification
The bench sends a short low glitch on the line. A receiver that starts a frame on the bare edge, without the mid-start recheck, would deliver a spurious byte. It sends frames with a deliberately wrong parity bit under both parity senses, and a frame with a low stop bit. A design with an inverted parity rule, or one that drops the byte on a framing error, shows wrong flags or a missing item in the scoreboard. It leaves a byte unread while a second frame lands, and then reads after that. A design that keeps the old byte, fails to flag the overrun, or clears the flags on the read is caught there. Back-to-back frames with alternating bit patterns expose a bit order reversed or an off-by-one in the sample counter.

// File: rtl/rxu_pkg.sv
package rxu_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_DATA  = 3'd2,
      ST_PAR   = 3'd3,
      ST_STOP  = 3'd4
   } rxu_state_e;

   // true when the ones count over data plus parity bit disagrees with the mode
   function automatic logic parity_bad(input logic ones_odd, input logic odd_mode);
      return ones_odd != odd_mode;
   endfunction

endpackage

// File: rtl/rxu_sync.sv
module rxu_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("rxu_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b1;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/rxu_sampler.sv
module rxu_sampler
   import rxu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_s,
   input  logic              odd_mode,
   output logic              done,
   output logic [DATA_W-1:0] frame_data,
   output logic              frame_perr,
   output logic              frame_ferr
);
   localparam int CW   = $clog2(OVS);
   localparam int IW   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam int HALF = OVS / 2;
   localparam logic [CW-1:0] CNT_HALF = CW'(HALF - 1);
   localparam logic [CW-1:0] CNT_FULL = CW'(OVS - 1);
   localparam logic [IW-1:0] IDX_LAST = IW'(DATA_W - 1);

   rxu_state_e        state;
   logic [CW-1:0]     cnt;
   logic [IW-1:0]     idx;
   logic [DATA_W-1:0] shreg;
   logic              par_bit;
   logic              rx_prev;
   logic              at_full;

   assign at_full = (cnt == CNT_FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cnt        <= '0;
         idx        <= '0;
         shreg      <= '0;
         par_bit    <= 1'b0;
         rx_prev    <= 1'b1;
         done       <= 1'b0;
         frame_data <= '0;
         frame_perr <= 1'b0;
         frame_ferr <= 1'b0;
      end else begin
         rx_prev <= rx_s;
         done    <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (rx_prev && !rx_s) begin
                  state <= ST_START;
                  cnt   <= '0;
               end
            end
            ST_START: begin
               if (cnt == CNT_HALF) begin
                  cnt <= '0;
                  idx <= '0;
                  state <= rx_s ? ST_IDLE : ST_DATA;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_DATA: begin
               if (at_full) begin
                  cnt   <= '0;
                  shreg <= {rx_s, shreg[DATA_W-1:1]};
                  if (idx == IDX_LAST) state <= ST_PAR;
                  else                 idx   <= idx + 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_PAR: begin
               if (at_full) begin
                  cnt     <= '0;
                  par_bit <= rx_s;
                  state   <= ST_STOP;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_STOP: begin
               if (at_full) begin
                  cnt        <= '0;
                  done       <= 1'b1;
                  frame_data <= shreg;
                  frame_perr <= parity_bad((^shreg) ^ par_bit, odd_mode);
                  frame_ferr <= !rx_s;
                  state      <= ST_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rxu_host.sv
module rxu_host #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [DATA_W-1:0] frame_data,
   input  logic              frame_perr,
   input  logic              frame_ferr,
   input  logic              rd_n,
   output logic [DATA_W-1:0] rx_byte,
   output logic              byte_ready,
   output logic              err_parity,
   output logic              err_frame,
   output logic              err_overrun
);
   logic [DATA_W-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q      <= '0;
         byte_ready  <= 1'b0;
         err_parity  <= 1'b0;
         err_frame   <= 1'b0;
         err_overrun <= 1'b0;
      end else if (done) begin
         hold_q      <= frame_data;
         err_parity  <= frame_perr;
         err_frame   <= frame_ferr;
         err_overrun <= byte_ready && rd_n;
         byte_ready  <= 1'b1;
      end else if (!rd_n) begin
         byte_ready  <= 1'b0;
      end
   end

   assign rx_byte = rd_n ? '0 : hold_q;
endmodule

// File: rtl/rxu_receiver.sv
module rxu_receiver #(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_serial,
   input  logic              odd_parity,
   input  logic              rd_n,
   output logic [DATA_W-1:0] rx_byte,
   output logic              byte_ready,
   output logic              err_parity,
   output logic              err_frame,
   output logic              err_overrun
);
   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_chk_ovs
         $error("rxu_receiver: OVS must be even and at least 4");
      end
      if (DATA_W < 2) begin : g_chk_w
         $error("rxu_receiver: DATA_W must be at least 2");
      end
   endgenerate

   logic              rx_s;
   logic              frame_done;
   logic [DATA_W-1:0] frame_data;
   logic              frame_perr;
   logic              frame_ferr;

   rxu_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rx_serial),
      .dout (rx_s)
   );

   rxu_sampler #(.DATA_W(DATA_W), .OVS(OVS)) u_samp (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_s      (rx_s),
      .odd_mode  (odd_parity),
      .done      (frame_done),
      .frame_data(frame_data),
      .frame_perr(frame_perr),
      .frame_ferr(frame_ferr)
   );

   rxu_host #(.DATA_W(DATA_W)) u_host (
      .clk        (clk),
      .rst_n      (rst_n),
      .done       (frame_done),
      .frame_data (frame_data),
      .frame_perr (frame_perr),
      .frame_ferr (frame_ferr),
      .rd_n       (rd_n),
      .rx_byte    (rx_byte),
      .byte_ready (byte_ready),
      .err_parity (err_parity),
      .err_frame  (err_frame),
      .err_overrun(err_overrun)
   );
endmodule

// File: rtl/rxu_checker.sv
module rxu_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_n,
   input logic [DATA_W-1:0] rx_byte,
   input logic              byte_ready,
   input logic              err_parity,
   input logic              err_frame,
   input logic              err_overrun,
   input logic              frame_done
);
   assert_ready_on_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> byte_ready);

   assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);

   assert_overrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && byte_ready && rd_n) |=> err_overrun);

   assert_overrun_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !byte_ready) |=> !err_overrun);

   assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n && !frame_done) |=> !byte_ready);

   assert_idle_out_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_n |-> (rx_byte == '0));

   assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_done |=> $stable({err_parity, err_frame, err_overrun}));
endmodule

bind rxu_receiver rxu_checker #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_n       (rd_n),
   .rx_byte    (rx_byte),
   .byte_ready (byte_ready),
   .err_parity (err_parity),
   .err_frame  (err_frame),
   .err_overrun(err_overrun),
   .frame_done (frame_done)
);

// File: tb/sim_rxu_receiver.sv
`timescale 1ns/1ps
module sim_rxu_receiver;
   localparam int W   = 8;
   localparam int OVS = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         rx_serial = 1'b1;
   logic         odd_parity = 1'b0;
   logic         rd_n = 1'b1;
   logic [W-1:0] rx_byte;
   logic         byte_ready, err_parity, err_frame, err_overrun;

   int total = 0;
   int bad   = 0;
   bit auto_read = 1'b0;
   bit mon_busy  = 1'b0;
   logic [W+2:0] expq[$];   // {ovr, ferr, perr, data}

   always #2.5 clk = ~clk;

   rxu_receiver #(.DATA_W(W), .OVS(OVS), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .rx_serial(rx_serial), .odd_parity(odd_parity),
      .rd_n(rd_n), .rx_byte(rx_byte), .byte_ready(byte_ready),
      .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [W-1:0] d, input bit wrong_par, input bit stop_v);
      logic p;
      p = (^d) ^ odd_parity ^ wrong_par;
      @(negedge clk) rx_serial = 1'b0;
      repeat (OVS) @(negedge clk);
      for (int i = 0; i < W; i++) begin
         rx_serial = d[i];
         repeat (OVS) @(negedge clk);
      end
      rx_serial = p;
      repeat (OVS) @(negedge clk);
      rx_serial = stop_v;
      repeat (OVS) @(negedge clk);
      rx_serial = 1'b1;
   endtask

   task automatic send_exp(input logic [W-1:0] d, input bit wrong_par, input bit stop_v);
      expq.push_back({1'b0, ~stop_v, wrong_par, d});
      send(d, wrong_par, stop_v);
   endtask

   task automatic monitor();
      logic [W+2:0] e;
      forever begin
         @(negedge clk);
         if (auto_read && byte_ready) begin
            mon_busy = 1'b1;
            if (expq.size() == 0) begin
               check("R2 unexpected byte", 32'd1, 32'd0);
               e = '0;
            end else e = expq.pop_front();
            check("R4 parity flag", 32'(err_parity), 32'(e[W]));
            check("R5 frame flag", 32'(err_frame), 32'(e[W+1]));
            check("R6 overrun flag", 32'(err_overrun), 32'(e[W+2]));
            rd_n = 1'b0;
            #1 check("R3 byte value", 32'(rx_byte), 32'(e[W-1:0]));
            @(negedge clk);
            rd_n = 1'b1;
            check("R7 ready cleared by read", 32'(byte_ready), 32'd0);
            check("R8 flags kept after read", 32'({err_overrun, err_frame, err_parity}),
                  32'(e[W+2:W]));
            #1 check("R7 output zero when idle", 32'(rx_byte), 32'd0);
            mon_busy = 1'b0;
         end
      end
   endtask

   task automatic drain();
      int n;
      n = 0;
      while ((expq.size() != 0 || mon_busy || byte_ready) && n < 1000) begin
         @(negedge clk);
         n++;
      end
      check("R3 scoreboard drained", 32'(expq.size()), 32'd0);
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      check("R1 ready", 32'(byte_ready), 32'd0);
      check("R1 flags", 32'({err_parity, err_frame, err_overrun}), 32'd0);
      check("R1 output", 32'(rx_byte), 32'd0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      fork monitor(); join_none
      auto_read = 1'b1;

      // R3 plain frames, even parity, back to back for R9
      send_exp(8'hA5, 1'b0, 1'b1);
      send_exp(8'h01, 1'b0, 1'b1);
      send_exp(8'h80, 1'b0, 1'b1);
      send_exp(8'h3C, 1'b0, 1'b1);
      drain();

      // R2 glitch shorter than half a bit
      @(negedge clk) rx_serial = 1'b0;
      repeat (3) @(negedge clk);
      rx_serial = 1'b1;
      repeat (250) @(negedge clk);
      check("R2 glitch gives no byte", 32'(byte_ready), 32'd0);
      check("R2 glitch queue", 32'(expq.size()), 32'd0);

      // R4 parity both senses, good and bad
      send_exp(8'hF0, 1'b1, 1'b1);
      drain();
      odd_parity = 1'b1;
      repeat (4) @(negedge clk);
      send_exp(8'h5A, 1'b0, 1'b1);
      send_exp(8'h07, 1'b1, 1'b1);
      drain();
      odd_parity = 1'b0;
      repeat (4) @(negedge clk);

      // R5 low stop bit
      send_exp(8'hC3, 1'b0, 1'b0);
      repeat (40) @(negedge clk);
      drain();
      send_exp(8'h99, 1'b0, 1'b1);
      drain();

      // R6 overrun, manual reads
      auto_read = 1'b0;
      send(8'h11, 1'b0, 1'b1);
      repeat (4) @(negedge clk);
      check("R6 first byte ready", 32'(byte_ready), 32'd1);
      check("R6 no overrun yet", 32'(err_overrun), 32'd0);
      send(8'h22, 1'b0, 1'b1);
      repeat (4) @(negedge clk);
      check("R6 overrun set", 32'(err_overrun), 32'd1);
      rd_n = 1'b0;
      #1 check("R6 new byte replaces old", 32'(rx_byte), 32'h22);
      @(negedge clk);
      rd_n = 1'b1;
      check("R7 ready cleared", 32'(byte_ready), 32'd0);
      check("R8 overrun held after read", 32'(err_overrun), 32'd1);
      repeat (10) @(negedge clk);
      check("R8 overrun still held", 32'(err_overrun), 32'd1);
      auto_read = 1'b1;
      send_exp(8'h6E, 1'b0, 1'b1);
      drain();
      check("R6 overrun clears on next read frame", 32'(err_overrun), 32'd0);

      finish_run();
   end
endmodule